// File: doc/BRIEF.md
# Shared Video RAM Slot Arbiter

This block sits between a host CPU, a CRT refresh controller and a single display RAM. It counts the dot clock into a character period and splits every period into two windows. In the first window the RAM address comes from the refresh controller. In the second window it comes from the CPU. It also produces a set of character-clock phase outputs. All phases share one frequency, and each phase is one dot clock behind the one before it.

A CPU access starts with a one-dot request pulse while `cpu_rdy` is high. The block captures the address, the direction and the write data, then drops `cpu_rdy`. It waits for the start of the next complete CPU window and spends that entire window on the access. A read loads RAM data into a holding register on the final dot of the window. The value stays there after the refresh window takes back the address lines. `cpu_rdy` goes high again on the dot after the window ends.

With the default parameters there are 8 dots per character. The refresh window covers dot counts 0 to 4 and the CPU window covers counts 5 to 7.

Top module: `vram_slot_arbiter`

## Requirements
- R1: The dot counter runs through 0 to CHAR_DOTS-1 and then wraps to 0. `char_ph[0]` is high exactly while the count is at least CHAR_DOTS/2, so it has a period of CHAR_DOTS dots.
- R2: For every k ≥ 1, `char_ph[k]` equals `char_ph[k-1]` delayed by one dot clock.
- R3: `cpu_sel` is high exactly for counts CHAR_DOTS-CPU_DOTS to CHAR_DOTS-1. While it is low, `ram_addr` equals `crt_addr`. While it is high, `ram_addr` equals the address of the most recently accepted CPU request, which is 0 after reset.
- R4: A request is accepted only when `cpu_req` is high while `cpu_rdy` is high. After acceptance, `cpu_rdy` is low until the access completes. A request made while `cpu_rdy` is low is ignored and changes no RAM contents.
- R5: An accepted access occupies the first complete CPU window that begins after the acceptance edge. A request accepted on the last refresh dot uses the very next window.
- R6: `ram_we` is high for all dots of the CPU window used by a write access, and at no other time. It is never high while `cpu_sel` is low. `ram_wdata` carries the captured data.
- R7: For a read access, `rd_stb` is high on the last dot of its CPU window. `cpu_rdata` takes the RAM data at the end of that dot and holds it until the next read completes.
- R8: `cpu_rdy` returns high on the dot that follows the last dot of the access window.
- R9: A synchronous reset sets the count to 0, clears all phases and `cpu_rdata`, deasserts `ram_we` and `rd_stb`, and drives `cpu_rdy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | One-dot CPU access request, honoured while `cpu_rdy` is high |
| cpu_we | input | 1 | 1 = write, 0 = read, sampled with the request |
| cpu_addr | input | ADDR_W | CPU RAM address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdy | output | 1 | High = ready, low = CPU held in wait |
| cpu_rdata | output | DATA_W | Holding register for read data |
| crt_addr | input | ADDR_W | Refresh address from the CRT controller |
| ram_addr | output | ADDR_W | Multiplexed RAM address |
| ram_wdata | output | DATA_W | Data to the RAM |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DATA_W | Data from the RAM |
| rd_stb | output | 1 | Read-data capture strobe |
| cpu_sel | output | 1 | High while the CPU owns the RAM address |
| char_ph | output | PHASES | Character clock phases, each one dot behind the previous |

## Verification
The assertions assume that the CPU raises `cpu_req` only as a pulse, and that it keeps the request attributes stable during the dot in which the pulse is sampled. They also assume reset is held for at least two dots, so that the history checks have settled values to look back on. The bench changes every input a short delay after the falling edge. Its requests arrive after 0 to 8 idle dots, so acceptance lands on every count of the character period. It also fires extra write pulses while an access is pending, and it expects those pulses to have no effect.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_WAIT = 2'd1,
      SLOT_BUSY = 2'd2
   } slot_state_t;
endpackage

// File: rtl/vram_dot_divider.sv
module vram_dot_divider #(
   parameter int CHAR_DOTS = 8,
   parameter int CPU_DOTS  = 3,
   parameter int PHASES    = 2
) (
   input  logic              clk,
   input  logic              rst,
   output logic              cpu_sel,
   output logic              slot_pre,
   output logic              slot_last,
   output logic [PHASES-1:0] char_ph
);
   localparam int CNT_W = (CHAR_DOTS > 2) ? $clog2(CHAR_DOTS) : 1;
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CHAR_DOTS - 1);
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(CHAR_DOTS / 2);
   localparam logic [CNT_W-1:0] CRT_C  = CNT_W'(CHAR_DOTS - CPU_DOTS);
   localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(CHAR_DOTS - CPU_DOTS - 1);

   logic [CNT_W-1:0] dot_cnt;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt   = (dot_cnt == LAST_C) ? '0 : dot_cnt + 1'b1;
   assign cpu_sel   = (dot_cnt >= CRT_C);
   assign slot_pre  = (dot_cnt == PRE_C);
   assign slot_last = (dot_cnt == LAST_C);

   always_ff @(posedge clk) begin
      if (rst) begin
         dot_cnt    <= '0;
         char_ph[0] <= 1'b0;
      end else begin
         dot_cnt    <= cnt_nxt;
         char_ph[0] <= (cnt_nxt >= HALF_C);
      end
   end

   for (genvar k = 1; k < PHASES; k++) begin : g_lag
      always_ff @(posedge clk) begin
         if (rst) char_ph[k] <= 1'b0;
         else     char_ph[k] <= char_ph[k-1];
      end

      AST_PH_LAG: assert property (@(posedge clk) disable iff (rst)
         $rose(char_ph[k-1]) |=> $rose(char_ph[k])) else $error("phase lag"); // R2
   end

   AST_PH_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(char_ph[0]) |-> (dot_cnt == HALF_C)) else $error("phase 0 rise"); // R1
endmodule

// File: rtl/vram_cpu_slot.sv
module vram_cpu_slot
   import vram_arb_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              slot_pre,
   input  logic              slot_last,
   input  logic              cpu_sel,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_rdy,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              ram_we,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              rd_stb
);
   slot_state_t state;
   logic        we_q;

   assign cpu_rdy = (state == SLOT_IDLE);
   assign ram_we  = (state == SLOT_BUSY) && we_q;
   assign rd_stb  = (state == SLOT_BUSY) && !we_q && slot_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= SLOT_IDLE;
         addr_q    <= '0;
         wdata_q   <= '0;
         we_q      <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         unique case (state)
            SLOT_IDLE: if (cpu_req) begin
               addr_q  <= cpu_addr;
               wdata_q <= cpu_wdata;
               we_q    <= cpu_we;
               state   <= slot_pre ? SLOT_BUSY : SLOT_WAIT;
            end
            SLOT_WAIT: if (slot_pre) state <= SLOT_BUSY;
            SLOT_BUSY: if (slot_last) begin
               state <= SLOT_IDLE;
               if (!we_q) cpu_rdata <= ram_rdata;
            end
            default: state <= SLOT_IDLE;
         endcase
      end
   end

   AST_WE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> cpu_sel) else $error("write outside slot"); // R6
   AST_RDY_DROP: assert property (@(posedge clk) disable iff (rst)
      $fell(cpu_rdy) |-> $past(cpu_req)) else $error("ready fell without request"); // R4
   AST_ACCESS_FULL: assert property (@(posedge clk) disable iff (rst)
      $rose(ram_we) |-> $past(slot_pre)) else $error("partial write slot"); // R5
   AST_RDY_AFTER: assert property (@(posedge clk) disable iff (rst)
      rd_stb |=> cpu_rdy) else $error("ready not released"); // R8
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(rd_stb) |-> $stable(cpu_rdata)) else $error("read data moved"); // R7
endmodule

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter #(
   parameter int ADDR_W    = 14,
   parameter int DATA_W    = 8,
   parameter int CHAR_DOTS = 8,
   parameter int CPU_DOTS  = 3,
   parameter int PHASES    = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_rdy,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [ADDR_W-1:0] crt_addr,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              ram_we,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              rd_stb,
   output logic              cpu_sel,
   output logic [PHASES-1:0] char_ph
);
   if (CHAR_DOTS < 2) begin : g_bad_dots
      $error("CHAR_DOTS must be at least 2");
   end
   if (CPU_DOTS < 1 || CPU_DOTS >= CHAR_DOTS) begin : g_bad_slot
      $error("CPU_DOTS must lie in 1..CHAR_DOTS-1");
   end
   if (PHASES < 1) begin : g_bad_ph
      $error("PHASES must be at least 1");
   end

   logic              slot_pre;
   logic              slot_last;
   logic [ADDR_W-1:0] cpu_addr_q;

   vram_dot_divider #(
      .CHAR_DOTS (CHAR_DOTS),
      .CPU_DOTS  (CPU_DOTS),
      .PHASES    (PHASES)
   ) u_div (
      .clk       (clk),
      .rst       (rst),
      .cpu_sel   (cpu_sel),
      .slot_pre  (slot_pre),
      .slot_last (slot_last),
      .char_ph   (char_ph)
   );

   vram_cpu_slot #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .slot_pre  (slot_pre),
      .slot_last (slot_last),
      .cpu_sel   (cpu_sel),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdy   (cpu_rdy),
      .cpu_rdata (cpu_rdata),
      .addr_q    (cpu_addr_q),
      .wdata_q   (ram_wdata),
      .ram_we    (ram_we),
      .ram_rdata (ram_rdata),
      .rd_stb    (rd_stb)
   );

   assign ram_addr = cpu_sel ? cpu_addr_q : crt_addr;

   AST_STB_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
      rd_stb |-> (cpu_sel && ram_addr == cpu_addr_q)) else $error("strobe outside slot"); // R7
endmodule

// File: tb/vram_slot_arbiter_test.sv
module vram_slot_arbiter_test;
   localparam int AW = 8, DW = 8, CD = 8, CPUD = 3, PH = 2;
   localparam int CRTD = CD - CPUD;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0, crt_addr = '0, ram_addr;
   logic [DW-1:0] cpu_wdata = '0, cpu_rdata, ram_wdata, ram_rdata;
   logic          cpu_rdy, ram_we, rd_stb, cpu_sel;
   logic [PH-1:0] char_ph;

   always #10 clk = ~clk;

   vram_slot_arbiter #(.ADDR_W(AW), .DATA_W(DW), .CHAR_DOTS(CD), .CPU_DOTS(CPUD), .PHASES(PH)) uut (
      .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata), .crt_addr(crt_addr),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
      .rd_stb(rd_stb), .cpu_sel(cpu_sel), .char_ph(char_ph));

   // Bench RAM and its independent shadow
   logic [DW-1:0] mem [0:255];
   logic [DW-1:0] shadow [0:255];
   assign ram_rdata = mem[ram_addr];
   always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

   int checks = 0, fails = 0;

   // Reference model: cycle index, pending access and its window
   int      cyc = 0, a_cyc = 0, s_cyc = 0;
   bit      busy = 0, m_we = 0;
   int      m_addr = 0, m_wdata = 0, m_rdata = 0;

   always @(posedge clk) begin
      if (rst) begin
         cyc = 0; busy = 0; m_addr = 0; m_rdata = 0; m_we = 0;
      end else begin
         bit take;
         take = !busy && cpu_req;
         if (busy && cyc == s_cyc + CPUD - 1) begin
            busy = 0;
            if (m_we) shadow[m_addr] = DW'(m_wdata);
            else      m_rdata = int'(shadow[m_addr]);
         end
         if (take) begin
            busy    = 1;
            a_cyc   = cyc;
            s_cyc   = a_cyc + 1 + ((CRTD - (a_cyc + 1) % CD + CD) % CD);
            m_we    = cpu_we;
            m_addr  = int'(cpu_addr);
            m_wdata = int'(cpu_wdata);
         end
         cyc = cyc + 1;
      end
   end

   task automatic chk(string req, string name, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, name, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      int  cnt;
      bit  e_sel, e_win;
      cnt   = cyc % CD;
      e_sel = (cnt >= CRTD);
      e_win = busy && cyc >= s_cyc;
      if (rst) begin
         chk("R9", "reset ready", int'(cpu_rdy), 1);
         chk("R9", "reset we", int'(ram_we), 0);
         chk("R9", "reset strobe", int'(rd_stb), 0);
         chk("R9", "reset phases", int'(char_ph), 0);
         chk("R9", "reset sel", int'(cpu_sel), 0);
         chk("R9", "reset rdata", int'(cpu_rdata), 0);
      end else begin
         chk("R1", "phase0", int'(char_ph[0]), int'(cnt >= CD / 2));
         chk("R2", "phase1", int'(char_ph[1]), int'(cyc >= 1 && ((cyc - 1) % CD) >= CD / 2));
         chk("R3", "cpu_sel", int'(cpu_sel), int'(e_sel));
         chk("R3", "ram_addr", int'(ram_addr), e_sel ? m_addr : int'(crt_addr));
         chk("R4 R8", "cpu_rdy", int'(cpu_rdy), int'(!busy));
         chk("R5 R6", "ram_we", int'(ram_we), int'(e_win && m_we));
         if (ram_we) chk("R6", "ram_wdata", int'(ram_wdata), m_wdata);
         chk("R7", "rd_stb", int'(rd_stb), int'(e_win && !m_we && cyc == s_cyc + CPUD - 1));
         chk("R7", "cpu_rdata", int'(cpu_rdata), m_rdata);
      end
   end

   task automatic issue(bit we, int addr, int data, int gap, bit poke);
      repeat (gap) begin
         @(negedge clk); #2;
         crt_addr = AW'($urandom);
      end
      while (!cpu_rdy) begin
         @(negedge clk); #2;
         crt_addr = AW'($urandom);
      end
      cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = DW'(data);
      @(negedge clk); #2;
      cpu_req = 1'b0; crt_addr = AW'($urandom);
      if (poke) begin
         // R4: a write pulse while waiting must be ignored
         cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(addr); cpu_wdata = 8'hEE;
         @(negedge clk); #2;
         cpu_req = 1'b0;
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]    = DW'(i * 3 + 1);
         shadow[i] = DW'(i * 3 + 1);
      end
      repeat (3) @(negedge clk);
      #2 rst = 1'b0;
      for (int i = 0; i < 18; i++) begin
         issue(1'b0, i * 7, 0, i % 9, i % 3 == 1);
         issue(1'b1, i * 7, 8'h40 + i, (i + 4) % 9, i % 4 == 2);
         issue(1'b0, i * 7, 0, i % 5, 1'b0);
      end
      issue(1'b0, 3, 0, 0, 1'b1);
      repeat (2 * CD) @(negedge clk);
      chk("R4", "ignored write left data", int'(mem[3]), int'(shadow[3]));
      chk("R4", "ignored write left data", int'(mem[7 * 5]), int'(shadow[7 * 5]));
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule